// File: doc/BRIEF.md
# Dual-Edge Set/Clear Flag

This block drives a flag that can be raised on the rising edge of a clock and dropped on the falling edge of the same clock. No register in it responds to both edges. Each flag lane is built from one register that updates on the rising edge and one that updates on the falling edge. The flag is the XOR of those two registers.

At a rising edge, a lane's register loads the value the flag should take, XORed with the partner register. At a falling edge, the partner does the same. After either edge, the XOR therefore equals the wanted level. A register flips only when its lane's flag must change, so at most one input of each output XOR moves per edge.

Typical use is to produce output strobes whose timing is tied to both clock phases, using only the single supplied clock. A parameter sets the number of independent lanes.

Top module: `dflag_top`

## Requirements
- R1: When `setCond[i]` is 1 at a rising edge of `clk`, `flag[i]` is 1 right after that edge.
- R2: When `clrCond[i]` is 1 at a falling edge of `clk`, `flag[i]` is 0 right after that edge.
- R3: While `rstN` is 0, every bit of `flag` is 0. This takes effect at once, with no clock edge needed.
- R4: A lane whose condition is 0 at an edge of its kind keeps its flag level through that edge. This means set=0 at a rising edge, or clear=0 at a falling edge.
- R5: The flag changes only after an edge of the matching kind. Changes on `setCond` or `clrCond` between edges do not move `flag`. `setCond` has no effect at a falling edge, and `clrCond` has no effect at a rising edge.
- R6: Per lane, at most one of the two internal registers flips per edge. Neither register flips when the flag already sits at the requested level, for example set=1 while the flag is already 1.
- R7: Lanes are independent. Each bit of `flag` depends only on the same bit of `setCond` and `clrCond`.
- R8: With both conditions held at 1, the flag is 1 during the high phase of `clk` and 0 during the low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; both edges are used |
| rstN | input | 1 | Asynchronous reset, active low |
| setCond | input | LANES | Per-lane set request, sampled on the rising edge |
| clrCond | input | LANES | Per-lane clear request, sampled on the falling edge |
| flag | output | LANES | Per-lane flag output |

## Verification
The bench builds the block with LANES=3 rather than the default of 1. With three lanes, a single edge can present different patterns at the same time: one lane set, one held, and one already at the requested level. This exercises lane independence and the no-flip rule together. Random set and clear patterns run against a reference model that is updated on both edges. Directed steps cover the pulse-per-cycle case, inputs moving between edges, and a reset applied in the middle of a phase.

// File: rtl/dflag_pkg.sv
package dflag_pkg;
  // Per-lane request from control to datapath: flip the rising-edge
  // register, the falling-edge register, or neither.
  typedef struct packed {
    logic riseFlip;
    logic fallFlip;
  } flipStrobe_t;
endpackage

// File: rtl/dflag_ctrl.sv
module dflag_ctrl
  import dflag_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic [LANES-1:0]        setCond,
  input  logic [LANES-1:0]        clrCond,
  input  logic [LANES-1:0]        flag,
  output flipStrobe_t [LANES-1:0] strobe
);
  // A register flips only when its edge must change the flag level.
  // This equals loading (wanted level XOR partner register).
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign strobe[i].riseFlip = setCond[i] & ~flag[i];
    assign strobe[i].fallFlip = clrCond[i] &  flag[i];
  end
endmodule

// File: rtl/dflag_dpath.sv
module dflag_dpath
  import dflag_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  flipStrobe_t [LANES-1:0] strobe,
  output logic [LANES-1:0]        riseQ,
  output logic [LANES-1:0]        fallQ,
  output logic [LANES-1:0]        flag
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) riseQ[i] <= 1'b0;
      else       riseQ[i] <= riseQ[i] ^ strobe[i].riseFlip;
    end

    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) fallQ[i] <= 1'b0;
      else       fallQ[i] <= fallQ[i] ^ strobe[i].fallFlip;
    end

    assign flag[i] = riseQ[i] ^ fallQ[i];
  end
endmodule

// File: rtl/dflag_top.sv
module dflag_top
  import dflag_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] setCond,
  input  logic [LANES-1:0] clrCond,
  output logic [LANES-1:0] flag
);
  flipStrobe_t [LANES-1:0] strobe;
  logic [LANES-1:0] riseQ;
  logic [LANES-1:0] fallQ;

  dflag_ctrl #(.LANES(LANES)) u_ctrl (
    .setCond(setCond),
    .clrCond(clrCond),
    .flag   (flag),
    .strobe (strobe)
  );

  dflag_dpath #(.LANES(LANES)) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .riseQ (riseQ),
    .fallQ (fallQ),
    .flag  (flag)
  );
endmodule

// File: rtl/dflag_chk.sv
module dflag_chk #(
  parameter int LANES = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [LANES-1:0] setCond,
  input logic [LANES-1:0] clrCond,
  input logic [LANES-1:0] flag,
  input logic [LANES-1:0] riseQ,
  input logic [LANES-1:0] fallQ
);
  logic [LANES-1:0] setSeen;
  logic [LANES-1:0] flagAtPos;
  logic [LANES-1:0] riseAtPos;
  logic [LANES-1:0] fallAtPos;
  logic [LANES-1:0] clrSeen;
  logic [LANES-1:0] flagAtNeg;
  logic [LANES-1:0] riseAtNeg;
  logic [LANES-1:0] fallAtNeg;

  // Values captured at a rising edge, taken before the edge updates them.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setSeen   <= '0;
      flagAtPos <= '0;
      riseAtPos <= '0;
      fallAtPos <= '0;
    end else begin
      setSeen   <= setCond;
      flagAtPos <= flag;
      riseAtPos <= riseQ;
      fallAtPos <= fallQ;
    end
  end

  // Values captured at a falling edge, taken before the edge updates them.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      clrSeen   <= '0;
      flagAtNeg <= '0;
      riseAtNeg <= '0;
      fallAtNeg <= '0;
    end else begin
      clrSeen   <= clrCond;
      flagAtNeg <= flag;
      riseAtNeg <= riseQ;
      fallAtNeg <= fallQ;
    end
  end

  a_r1_set_takes: assert property (@(negedge clk) disable iff (!rstN)
    (setSeen & ~flag) == '0);

  a_r2_clr_takes: assert property (@(posedge clk) disable iff (!rstN)
    (clrSeen & flag) == '0);

  a_r3_reset_zero: assert property (@(posedge clk)
    !rstN |-> (flag == '0 && riseQ == '0 && fallQ == '0));

  a_r4_hold_rise: assert property (@(negedge clk) disable iff (!rstN)
    (~setSeen & (flag ^ flagAtPos)) == '0);

  a_r4_hold_fall: assert property (@(posedge clk) disable iff (!rstN)
    (~clrSeen & (flag ^ flagAtNeg)) == '0);

  a_r5_rise_reg_quiet: assert property (@(posedge clk) disable iff (!rstN)
    riseQ == riseAtNeg);

  a_r5_fall_reg_quiet: assert property (@(negedge clk) disable iff (!rstN)
    fallQ == fallAtPos);

  a_r6_no_flip_set: assert property (@(negedge clk) disable iff (!rstN)
    (setSeen & flagAtPos & (riseQ ^ riseAtPos)) == '0);

  a_r6_no_flip_clr: assert property (@(posedge clk) disable iff (!rstN)
    (clrSeen & ~flagAtNeg & (fallQ ^ fallAtNeg)) == '0);
endmodule

bind dflag_top dflag_chk #(.LANES(LANES)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .setCond(setCond),
  .clrCond(clrCond),
  .flag   (flag),
  .riseQ  (riseQ),
  .fallQ  (fallQ)
);

// File: tb/sim_dflag_top.sv
module sim_dflag_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 3;

  logic clk = 1'b0;
  logic rstN;
  logic [LANES-1:0] setCond;
  logic [LANES-1:0] clrCond;
  logic [LANES-1:0] flag;
  logic [LANES-1:0] model;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  dflag_top #(.LANES(LANES)) u0 (
    .clk    (clk),
    .rstN   (rstN),
    .setCond(setCond),
    .clrCond(clrCond),
    .flag   (flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [LANES-1:0] afterRise(input logic [LANES-1:0] cur,
                                                 input logic [LANES-1:0] s);
    return cur | s;
  endfunction

  function automatic logic [LANES-1:0] afterFall(input logic [LANES-1:0] cur,
                                                 input logic [LANES-1:0] c);
    return cur & ~c;
  endfunction

  task automatic checkFlag(input string tag);
    checks++;
    if (flag !== model) begin
      errors++;
      $display("FAIL %s: flag=%b expected=%b", tag, flag, model);
    end
  endtask

  // Start just after a falling edge; finish just after the rising edge.
  task automatic riseStep(input logic [LANES-1:0] s, input logic [LANES-1:0] c,
                          input string tag);
    setCond = s;
    clrCond = c;
    #1 checkFlag({tag, " R5 before rising edge"});
    @(posedge clk);
    #1 model = afterRise(model, s);
    checkFlag(tag);
  endtask

  // Start just after a rising edge; finish just after the falling edge.
  task automatic fallStep(input logic [LANES-1:0] s, input logic [LANES-1:0] c,
                          input string tag);
    setCond = s;
    clrCond = c;
    #1 checkFlag({tag, " R5 before falling edge"});
    @(negedge clk);
    #1 model = afterFall(model, c);
    checkFlag(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    setCond = '0;
    clrCond = '0;
    model   = '0;
    rstN    = 1'b1;
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 checkFlag("R3 reset level");
    @(negedge clk);
    #1 rstN = 1'b1;

    // R1 set lane 0, R7 other lanes untouched
    riseStep(3'b001, 3'b000, "R1 R7 set lane0");
    // R4 clear low holds through falling edge
    fallStep(3'b000, 3'b000, "R4 hold at falling edge");
    // R6 set again while already high, R7 set lane 2 alone
    riseStep(3'b101, 3'b000, "R6 R7 set while high");
    // R2 clear lane 0 only; R5 set held high has no effect at falling edge
    fallStep(3'b111, 3'b001, "R2 R5 clear lane0, set ignored");
    // R4 set low holds through rising edge; R5 clear ignored at rising edge
    riseStep(3'b000, 3'b111, "R4 R5 hold at rising, clear ignored");
    fallStep(3'b000, 3'b111, "R2 clear all");
    riseStep(3'b000, 3'b000, "R4 idle rising");
    // R8 pulse per cycle with both conditions held high
    for (int k = 0; k < 3; k++) begin
      riseStep(3'b111, 3'b111, "R8 high phase");
      fallStep(3'b111, 3'b111, "R8 low phase");
    end

    // R3 asynchronous reset in mid phase with flags high
    riseStep(3'b111, 3'b000, "R1 set all");
    setCond = '0;
    clrCond = '0;
    #1 rstN = 1'b0;
    #1 model = '0;
    checkFlag("R3 async reset without edge");
    @(negedge clk);
    #1 rstN = 1'b1;
    checkFlag("R3 after release");

    // Random patterns
    void'($urandom(32'd2718));
    for (int n = 0; n < 2000; n++) begin
      riseStep(LANES'($urandom), LANES'($urandom), "R1/R4/R6/R7 random rising");
      fallStep(LANES'($urandom), LANES'($urandom), "R2/R4/R5/R7 random falling");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule